// File: doc/BRIEF.md
# Fractional Scale-Step Baud Generator

This block derives a serial-port bit-rate tick, or an oversampling tick, from the system clock. An integer prescaler first divides the clock by (scale + 1). On each prescaler wrap, a 17-bit phase accumulator adds a 16-bit step value. Every carry out of the accumulator produces a single-cycle tick. The average tick rate is therefore clk × step / ((scale + 1) × 2^17). This gives fine rate resolution without a wide integer divider.

Software chooses scale and step for the wanted rate and writes both in one 32-bit configuration word, using a one-cycle write strobe. A write loads the new fields and restarts both counters from zero. An enable input freezes the whole generator without losing its phase.

Top module: `nco_baud_gen`

## Requirements
- R1: After reset, `tick` is low, and the reset configuration (step 0) produces no tick while enabled, until a configuration is written.
- R2: Over M enabled cycles after a configuration write, the number of ticks is floor(floor(M / (scale + 1)) × step / 2^17).
- R3: The scale value is taken from `cfgWord[27:16]` and the step value from `cfgWord[15:0]`. Bits 31:28 have no effect on the tick stream.
- R4: A scale of 0 divides by one: the accumulator advances on every enabled clock, so with step 65535 the first tick follows the 3rd enabled edge after the write.
- R5: Each tick lasts exactly one cycle, and two ticks never fall on consecutive cycles.
- R6: A step of 0 produces no ticks at all, for any scale.
- R7: A configuration write clears the prescaler and the accumulator at the edge that samples `cfgWe`. Phase built up before the write does not carry over.
- R8: While `enable` is low, both counters hold their values and no tick is produced. After `enable` returns high, counting resumes from the held phase.
- R9: The first tick after a write comes ceil(2^17 / step) × (scale + 1) enabled edges after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Advance counters when high; hold when low |
| cfgWe | input | 1 | One-cycle strobe that loads `cfgWord` and restarts the counters |
| cfgWord | input | 32 | Configuration: scale in bits 27:16, step in bits 15:0 |
| tick | output | 1 | One-cycle rate tick |

## Verification
The write edge that samples `cfgWe` clears both counters. `tick` is a register, so a carry made at enabled edge k shows at `tick` right after that edge. The bench drives inputs on the falling edge and samples `tick` on the next falling edge. The tick it sees there belongs to the enabled edge just passed. Counts over a window of M edges and first-tick positions are computed in the bench from the rate formula and the ceil(2^17 / step) × (scale + 1) rule. The hold and restart checks rely on a one-cycle latency: a freeze or a write takes effect at the very next edge.

// File: rtl/nco_baud_pkg.sv
package nco_baud_pkg;
  // Strobes from the prescaler control to the accumulator datapath.
  typedef struct packed {
    logic clear;    // configuration write: reload step, zero phase
    logic advance;  // prescaler terminal count: add step to phase
  } strobes_t;
endpackage

// File: rtl/nco_baud_ctrl.sv
module nco_baud_ctrl
  import nco_baud_pkg::*;
#(
  parameter int SCALE_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               cfgWe,
  input  logic [SCALE_W-1:0] scaleIn,
  output strobes_t           strobes
);
  localparam logic [SCALE_W-1:0] ONE = {{(SCALE_W-1){1'b0}}, 1'b1};

  logic [SCALE_W-1:0] scaleReg;
  logic [SCALE_W-1:0] preCnt;
  logic               terminal;

  assign terminal        = (preCnt == scaleReg);
  assign strobes.clear   = cfgWe;
  assign strobes.advance = enable && !cfgWe && terminal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scaleReg <= '0;
      preCnt   <= '0;
    end else if (cfgWe) begin
      scaleReg <= scaleIn;
      preCnt   <= '0;
    end else if (enable) begin
      preCnt <= terminal ? '0 : preCnt + ONE;
    end
  end

  // R7: a write restarts the prescaler
  a_r7_cnt_clear: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> (preCnt == '0));

  // R8: prescaler frozen while disabled
  a_r8_cnt_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !cfgWe) |=> $stable(preCnt));

  // R2: prescaler never runs past the programmed scale
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= scaleReg);

  // R4: with scale 0 every enabled cycle advances the accumulator
  a_r4_every_clock: assert property (@(posedge clk) disable iff (!rstN)
    (scaleReg == '0 && enable && !cfgWe) |=> (preCnt == '0));
endmodule

// File: rtl/nco_baud_accum.sv
module nco_baud_accum
  import nco_baud_pkg::*;
#(
  parameter int STEP_W = 16,
  parameter int ACC_W  = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [STEP_W-1:0] stepIn,
  output logic              tick
);
  localparam int PAD_W = ACC_W + 1 - STEP_W;

  logic [STEP_W-1:0] stepReg;
  logic [ACC_W-1:0]  acc;
  logic [ACC_W:0]    sum;
  logic              tickQ;

  assign sum  = {1'b0, acc} + {{PAD_W{1'b0}}, stepReg};
  assign tick = tickQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepReg <= '0;
      acc     <= '0;
      tickQ   <= 1'b0;
    end else if (strobes.clear) begin
      stepReg <= stepIn;
      acc     <= '0;
      tickQ   <= 1'b0;
    end else if (strobes.advance) begin
      acc   <= sum[ACC_W-1:0];
      tickQ <= sum[ACC_W];
    end else begin
      tickQ <= 1'b0;
    end
  end

  // R5: a tick is one cycle wide and never repeats on the next cycle
  a_r5_single_tick: assert property (@(posedge clk) disable iff (!rstN)
    tickQ |=> !tickQ);

  // R6: zero step never carries
  a_r6_zero_step: assert property (@(posedge clk) disable iff (!rstN)
    (stepReg == '0 && !strobes.clear) |=> !tickQ);

  // R7: a write zeroes the phase
  a_r7_acc_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (acc == '0 && !tickQ));

  // R8: phase held between advances
  a_r8_acc_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.advance && !strobes.clear) |=> ($stable(acc) && !tickQ));
endmodule

// File: rtl/nco_baud_gen.sv
module nco_baud_gen
  import nco_baud_pkg::*;
#(
  parameter int CFG_W     = 32,
  parameter int SCALE_W   = 12,
  parameter int SCALE_LSB = 16,
  parameter int STEP_W    = 16,
  parameter int STEP_LSB  = 0,
  parameter int ACC_W     = 17
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWord,
  output logic             tick
);
  localparam int SCALE_MSB = SCALE_LSB + SCALE_W - 1;
  localparam int STEP_MSB  = STEP_LSB + STEP_W - 1;

  strobes_t strobes;
  logic     unusedCfgBits;

  assign unusedCfgBits = ^cfgWord[CFG_W-1:SCALE_MSB+1];

  nco_baud_ctrl #(.SCALE_W(SCALE_W)) ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .cfgWe   (cfgWe),
    .scaleIn (cfgWord[SCALE_MSB:SCALE_LSB]),
    .strobes (strobes)
  );

  nco_baud_accum #(.STEP_W(STEP_W), .ACC_W(ACC_W)) accum (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .stepIn  (cfgWord[STEP_MSB:STEP_LSB]),
    .tick    (tick)
  );

  // R8: no tick follows a disabled cycle
  a_r8_no_tick_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !cfgWe) |=> !tick);
endmodule

// File: tb/nco_baud_gen_test.sv
module nco_baud_gen_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        cfgWe = 1'b0;
  logic [31:0] cfgWord = '0;
  logic        tick;

  int checks = 0;
  int failures = 0;
  int ticksSeen;
  int firstTick;
  int doubles = 0;
  logic prevTick = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  nco_baud_gen uut (
    .clk(clk), .rstN(rstN), .enable(enable),
    .cfgWe(cfgWe), .cfgWord(cfgWord), .tick(tick)
  );

  typedef struct packed {
    int junk;    // value for bits 31:28
    int scale;
    int step;
    int cycles;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{0,  0,    65535, 1000},
    '{0,  0,    32768, 400},
    '{15, 3,    65535, 2000},
    '{10, 9,    13107, 20000},
    '{0,  5,    0,     500},
    '{7,  4095, 65535, 40960}
  };

  task automatic check(string tag, longint actual, longint expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic writeCfg(int junk, int scale, int step);
    cfgWord = {junk[3:0], scale[11:0], step[15:0]};
    cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic countTicks(int m);
    ticksSeen = 0;
    firstTick = -1;
    for (int i = 1; i <= m; i++) begin
      @(negedge clk);
      if (tick) begin
        if (prevTick) doubles++;
        ticksSeen++;
        if (firstTick < 0) firstTick = i;
      end
      prevTick = tick;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 tick low in reset", tick, 0);
    rstN = 1'b1;
    enable = 1'b1;
    countTicks(200);
    check("R1 no ticks with reset configuration", ticksSeen, 0);

    // table of rate vectors
    for (int v = 0; v < NVEC; v++) begin
      longint adds, expTicks, expFirst;
      adds = longint'(VECS[v].cycles / (VECS[v].scale + 1));
      expTicks = (adds * VECS[v].step) >> 17;
      if (VECS[v].step == 0) expFirst = -1;
      else expFirst = ((131072 + VECS[v].step - 1) / VECS[v].step) * (VECS[v].scale + 1);
      if (expFirst > VECS[v].cycles) expFirst = -1;
      prevTick = 1'b0;
      writeCfg(VECS[v].junk, VECS[v].scale, VECS[v].step);
      check("R7 tick cleared by write", tick, 0);
      countTicks(VECS[v].cycles);
      check($sformatf("R2 R3 R6 tick count vector %0d", v), ticksSeen, expTicks);
      check($sformatf("R9 first tick vector %0d", v), firstTick, expFirst);
    end
    check("R5 no back-to-back ticks", doubles, 0);

    // R4: scale 0, step 65535 -> first tick after enabled edge 3
    writeCfg(0, 0, 65535);
    countTicks(3);
    check("R4 scale 0 first tick edge", firstTick, 3);

    // R7: phase built up is discarded by a rewrite
    writeCfg(0, 0, 32768);
    countTicks(3);
    check("R7 no tick before rewrite", ticksSeen, 0);
    writeCfg(0, 0, 32768);
    countTicks(3);
    check("R7 rewrite restarts phase", ticksSeen, 0);
    countTicks(1);
    check("R7 tick on 4th add after rewrite", ticksSeen, 1);

    // R8: freeze holds prescaler and phase
    writeCfg(0, 1, 65535);
    countTicks(5);
    check("R8 no tick before freeze", ticksSeen, 0);
    enable = 1'b0;
    countTicks(40);
    check("R8 no tick while disabled", ticksSeen, 0);
    enable = 1'b1;
    countTicks(1);
    check("R8 resume from held phase", ticksSeen, 1);
    countTicks(1);
    check("R5 tick lasts one cycle", tick, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule